// File: doc/BRIEF.md
# Addressed Scan-Bridge Selection Controller

This block decides whether one bridge in a multi-drop boundary-scan network is taken into the active scan chain. It runs beside a standard TAP controller, which is not part of the block, and reads its state strobes: test-logic-reset, shift-IR, shift-DR and update-IR. It also takes the serial test data input, a static slot address and the value of a small group register. From these it shifts an instruction register, tracks a selection state and gates the test data output.

Each instruction-register update made while the block waits for an address is read as an address. The code may name one slot (direct), every bridge (broadcast), or one of four multi-cast groups. A device selected on its own slot drives test data out as a normal 1149.1 device. In that mode the identification register is the active data register and the group register may be accessed. In broadcast and multi-cast modes the output driver is never enabled, so identical boards on a shared bus cannot contend. A reserved return opcode sends a selected or unselected device back to waiting for an address.

Top module: `scan_sel_ctrl`

## Requirements
- R1: After rst_ni low, or at any rising edge of tck_i with tlr_i high, sel_state_o becomes 0 (wait-for-address). tlr_i takes priority over update_ir_i in the same cycle.
- R2: At each rising edge with shift_ir_i high, ir_o shifts right and tdi_i enters bit 7. The bit leaving bit 0 is lost. While waiting for an address, tdo_en_o stays low during shifting.
- R3: The address decode looks only at ir_o[5:0]. Bits 7..6 have no effect on which state is reached from wait-for-address.
- R4: From wait-for-address, an update with code 0x00..0x3A equal to slot_i gives sel_state_o = 1 (single). Any other code in that range gives 4 (unselected). A slot_i of 0x3B..0x3F never yields a direct match.
- R5: From wait-for-address, code 0x3B gives 2 (broadcast). Code 0x3C..0x3F gives 3 (multi-cast) when grp_i equals the code's two low bits, and gives 4 otherwise.
- R6: tdo_en_o is updated on the falling edge of tck_i. It is high only when the state is single and shift_ir_i or shift_dr_i is high, and it is low in every other state.
- R7: idcode_sel_o goes high on entry to single. It is cleared by the next update-IR or by test-logic-reset.
- R8: An unselected device keeps state 4 through any update except one that loads 0xC0. Test-logic-reset also ends it.
- R9: An update loading 0xC0 returns states 1, 2, 3 and 4 to 0. In wait-for-address, 0xC0 is decoded as direct address 0x00.
- R10: grp_en_o is high exactly while the state is single.
- R11: A state change caused by update-IR appears at the same rising edge at which update_ir_i is sampled high, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tlr_i | input | 1 | TAP is in test-logic-reset |
| shift_ir_i | input | 1 | TAP is in shift-IR |
| shift_dr_i | input | 1 | TAP is in shift-DR |
| update_ir_i | input | 1 | TAP is in update-IR |
| tdi_i | input | 1 | Serial test data in |
| slot_i | input | 6 | Static slot address |
| grp_i | input | 2 | Multi-cast group register value |
| ir_o | output | 8 | Instruction register contents |
| sel_state_o | output | 3 | 0 wait, 1 single, 2 broadcast, 3 multi-cast, 4 unselected |
| tdo_en_o | output | 1 | Test data output drive enable |
| idcode_sel_o | output | 1 | Identification register is the active data register |
| grp_en_o | output | 1 | Group register access allowed |

## Verification
Test-logic-reset and an address-carrying update can land in the same cycle. The bench loads a code that matches the slot, then raises tlr_i together with update_ir_i. It expects state 0 and idcode_sel_o low rather than a selection. A second collision pairs shift-DR with entry into broadcast. In that case tdo_en_o must stay low even though a shift strobe is present.

// File: rtl/scan_sel_pkg.sv
package scan_sel_pkg;
  typedef enum logic [2:0] {
    ST_WAIT   = 3'd0,
    ST_SINGLE = 3'd1,
    ST_BCAST  = 3'd2,
    ST_MCAST  = 3'd3,
    ST_UNSEL  = 3'd4
  } sel_state_e;
endpackage

// File: rtl/scan_sel_ir.sv
module scan_sel_ir #(
  parameter int IR_W = 8
) (
  input  logic            tck_i,
  input  logic            rst_ni,
  input  logic            shift_i,
  input  logic            tdi_i,
  output logic [IR_W-1:0] ir_o
);
  logic [IR_W-1:0] ir_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)      ir_q <= '0;
    else if (shift_i) ir_q <= {tdi_i, ir_q[IR_W-1:1]};
  end

  assign ir_o = ir_q;

  AST_IR_SHIFT: assert property (@(posedge tck_i) disable iff (!rst_ni)
    shift_i |=> (ir_q[IR_W-1] == $past(tdi_i)) && (ir_q[IR_W-2:0] == $past(ir_q[IR_W-1:1]))); // R2
endmodule

// File: rtl/scan_sel_decode.sv
module scan_sel_decode #(
  parameter int IR_W   = 8,
  parameter int ADDR_W = 6,
  parameter int GRP_W  = 2
) (
  input  logic [IR_W-1:0]   ir_i,
  input  logic [ADDR_W-1:0] slot_i,
  input  logic [GRP_W-1:0]  grp_i,
  output logic              hit_single_o,
  output logic              hit_bcast_o,
  output logic              hit_mcast_o,
  output logic              gotowait_o
);
  localparam logic [ADDR_W-1:0] GRP_BASE    = ADDR_W'((1 << ADDR_W) - (1 << GRP_W));
  localparam logic [ADDR_W-1:0] BCAST_CODE  = GRP_BASE - 1'b1;
  localparam logic [ADDR_W-1:0] LAST_DIRECT = BCAST_CODE - 1'b1;
  localparam logic [IR_W-1:0]   GOTOWAIT    = IR_W'(((1 << (IR_W - ADDR_W)) - 1) << ADDR_W);

  logic [ADDR_W-1:0] code;
  logic              is_direct;

  assign code         = ir_i[ADDR_W-1:0];
  assign is_direct    = (code <= LAST_DIRECT);
  assign hit_single_o = is_direct && (code == slot_i);
  assign hit_bcast_o  = (code == BCAST_CODE);
  assign hit_mcast_o  = (code >= GRP_BASE) && (code[GRP_W-1:0] == grp_i);
  assign gotowait_o   = (ir_i == GOTOWAIT);

  always_comb begin
    AST_DEC_EXCL: assert ($onehot0({hit_single_o, hit_bcast_o, hit_mcast_o})); // R5
  end
endmodule

// File: rtl/scan_sel_fsm.sv
module scan_sel_fsm
  import scan_sel_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tlr_i,
  input  logic       update_i,
  input  logic       hit_single_i,
  input  logic       hit_bcast_i,
  input  logic       hit_mcast_i,
  input  logic       gotowait_i,
  output sel_state_e state_o,
  output logic       idcode_sel_o
);
  sel_state_e state_q, state_d;
  logic       id_q, id_d;

  always_comb begin
    state_d = state_q;
    id_d    = id_q;
    if (tlr_i) begin
      state_d = ST_WAIT;
      id_d    = 1'b0;
    end else if (update_i) begin
      id_d = 1'b0;
      if (state_q == ST_WAIT) begin
        if (hit_single_i) begin
          state_d = ST_SINGLE;
          id_d    = 1'b1;
        end else if (hit_bcast_i) state_d = ST_BCAST;
        else if (hit_mcast_i)     state_d = ST_MCAST;
        else                      state_d = ST_UNSEL;
      end else if (gotowait_i) begin
        state_d = ST_WAIT;
      end
    end
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAIT;
      id_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      id_q    <= id_d;
    end
  end

  assign state_o      = state_q;
  assign idcode_sel_o = id_q;

  AST_TLR_WAIT: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tlr_i |=> (state_q == ST_WAIT) && !id_q); // R1
  AST_UNSEL_HOLD: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state_q == ST_UNSEL) && !tlr_i && !(update_i && gotowait_i) |=> state_q == ST_UNSEL); // R8
  AST_ID_ENTRY: assert property (@(posedge tck_i) disable iff (!rst_ni)
    $rose(state_q == ST_SINGLE) |-> id_q); // R7
  AST_NO_IDLE_MOVE: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !tlr_i && !update_i |=> $stable(state_q)); // R11
endmodule

// File: rtl/scan_sel_tdo.sv
module scan_sel_tdo (
  input  logic tck_i,
  input  logic rst_ni,
  input  logic single_i,
  input  logic shift_ir_i,
  input  logic shift_dr_i,
  output logic tdo_en_o
);
  logic en_q;

  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= single_i && (shift_ir_i || shift_dr_i);
  end

  assign tdo_en_o = en_q;
endmodule

// File: rtl/scan_sel_ctrl.sv
module scan_sel_ctrl
  import scan_sel_pkg::*;
#(
  parameter int IR_W   = 8,
  parameter int ADDR_W = 6,
  parameter int GRP_W  = 2
) (
  input  logic              tck_i,
  input  logic              rst_ni,
  input  logic              tlr_i,
  input  logic              shift_ir_i,
  input  logic              shift_dr_i,
  input  logic              update_ir_i,
  input  logic              tdi_i,
  input  logic [ADDR_W-1:0] slot_i,
  input  logic [GRP_W-1:0]  grp_i,
  output logic [IR_W-1:0]   ir_o,
  output logic [2:0]        sel_state_o,
  output logic              tdo_en_o,
  output logic              idcode_sel_o,
  output logic              grp_en_o
);
  localparam logic [ADDR_W-1:0] LAST_DIRECT = ADDR_W'((1 << ADDR_W) - (1 << GRP_W) - 2);

  logic [IR_W-1:0] ir;
  logic            hit_single, hit_bcast, hit_mcast, gotowait;
  sel_state_e      state;

  scan_sel_ir #(.IR_W(IR_W)) u_ir (
    .tck_i   (tck_i),
    .rst_ni  (rst_ni),
    .shift_i (shift_ir_i),
    .tdi_i   (tdi_i),
    .ir_o    (ir)
  );

  scan_sel_decode #(.IR_W(IR_W), .ADDR_W(ADDR_W), .GRP_W(GRP_W)) u_dec (
    .ir_i         (ir),
    .slot_i       (slot_i),
    .grp_i        (grp_i),
    .hit_single_o (hit_single),
    .hit_bcast_o  (hit_bcast),
    .hit_mcast_o  (hit_mcast),
    .gotowait_o   (gotowait)
  );

  scan_sel_fsm u_fsm (
    .tck_i        (tck_i),
    .rst_ni       (rst_ni),
    .tlr_i        (tlr_i),
    .update_i     (update_ir_i),
    .hit_single_i (hit_single),
    .hit_bcast_i  (hit_bcast),
    .hit_mcast_i  (hit_mcast),
    .gotowait_i   (gotowait),
    .state_o      (state),
    .idcode_sel_o (idcode_sel_o)
  );

  scan_sel_tdo u_tdo (
    .tck_i      (tck_i),
    .rst_ni     (rst_ni),
    .single_i   (state == ST_SINGLE),
    .shift_ir_i (shift_ir_i),
    .shift_dr_i (shift_dr_i),
    .tdo_en_o   (tdo_en_o)
  );

  assign ir_o        = ir;
  assign sel_state_o = state;
  assign grp_en_o    = (state == ST_SINGLE);

  AST_TDO_ONLY_SINGLE: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tdo_en_o |-> state == ST_SINGLE); // R6
  AST_DIRECT_MATCH: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state == ST_WAIT) && update_ir_i && !tlr_i && (ir[ADDR_W-1:0] == slot_i) && (slot_i <= LAST_DIRECT)
    |=> state == ST_SINGLE); // R4
  AST_BCAST_NO_ID: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state == ST_BCAST) || (state == ST_MCAST) |-> !idcode_sel_o && !tdo_en_o); // R6
endmodule

// File: tb/scan_sel_ctrl_tb_top.sv
module scan_sel_ctrl_tb_top;
  logic       tck = 1'b0;
  logic       rst_n = 1'b0;
  logic       tlr = 1'b0, shift_ir = 1'b0, shift_dr = 1'b0, update_ir = 1'b0, tdi = 1'b0;
  logic [5:0] slot = 6'h05;
  logic [1:0] grp = 2'd0;
  logic [7:0] ir;
  logic [2:0] st;
  logic       tdo_en, id_sel, grp_en;
  int checks = 0, fails = 0;

  always #5 tck = ~tck;

  scan_sel_ctrl dut_i (
    .tck_i(tck), .rst_ni(rst_n), .tlr_i(tlr), .shift_ir_i(shift_ir), .shift_dr_i(shift_dr),
    .update_ir_i(update_ir), .tdi_i(tdi), .slot_i(slot), .grp_i(grp),
    .ir_o(ir), .sel_state_o(st), .tdo_en_o(tdo_en), .idcode_sel_o(id_sel), .grp_en_o(grp_en)
  );

  // slot[18:13] grp[12:11] code[10:3] expected state[2:0]
  localparam int NV = 12;
  localparam logic [18:0] VEC [NV] = '{
    {6'h05, 2'd0, 8'h05, 3'd1},  // R4 direct match
    {6'h05, 2'd0, 8'h06, 3'd4},  // R4 mismatch
    {6'h05, 2'd0, 8'hC5, 3'd1},  // R3 high bits ignored
    {6'h05, 2'd0, 8'h3B, 3'd2},  // R5 broadcast
    {6'h05, 2'd2, 8'h3E, 3'd3},  // R5 group hit
    {6'h05, 2'd1, 8'h3E, 3'd4},  // R5 group miss
    {6'h3A, 2'd0, 8'h3A, 3'd1},  // R4 highest direct
    {6'h3B, 2'd0, 8'h3B, 3'd2},  // R4 slot 3B -> broadcast only
    {6'h3D, 2'd1, 8'h3D, 3'd3},  // R4 slot 3D via group only
    {6'h3D, 2'd0, 8'h3D, 3'd4},  // R4 slot 3D no direct match
    {6'h00, 2'd0, 8'h00, 3'd1},  // R4 slot zero
    {6'h05, 2'd3, 8'hFF, 3'd3}   // R3 R5 group 3 with high bits
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge tck);
    #6;
  endtask

  task automatic shift_byte(input logic [7:0] v);
    shift_ir = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tdi = v[i];
      tick();
    end
    shift_ir = 1'b0;
  endtask

  task automatic update();
    update_ir = 1'b1;
    tick();
    update_ir = 1'b0;
  endtask

  task automatic load(input logic [7:0] v);
    shift_byte(v);
    update();
  endtask

  task automatic go_wait();
    tlr = 1'b1;
    tick();
    tlr = 1'b0;
  endtask

  initial begin
    #2000000;
    fails++;
    checks++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1;
    chk("R1 reset state", {29'd0, st}, 0);
    #20;
    rst_n = 1'b1;
    tick();
    chk("R1 reset state", {29'd0, st}, 0);
    chk("R6 reset tdo_en", tdo_en, 0);
    chk("R7 reset idcode", id_sel, 0);
    chk("R10 reset grp_en", grp_en, 0);

    // R2 shift in wait: TDO silent, byte lands LSB-first
    shift_ir = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tdi = 8'hA6 >> i;
      tick();
      chk("R2 tdo_en in wait", tdo_en, 0);
    end
    shift_ir = 1'b0;
    chk("R2 ir contents", ir, 8'hA6);

    for (int k = 0; k < NV; k++) begin
      slot = VEC[k][18:13];
      grp  = VEC[k][12:11];
      go_wait();
      load(VEC[k][10:3]);
      chk("R4 R5 state", {29'd0, st}, {29'd0, VEC[k][2:0]});
      chk("R10 grp_en", grp_en, VEC[k][2:0] == 3'd1);
      chk("R7 idcode", id_sel, VEC[k][2:0] == 3'd1);
      shift_dr = 1'b1;
      tick();
      shift_dr = 1'b0;
      chk("R6 tdo_en", tdo_en, VEC[k][2:0] == 3'd1);
      tick();
      chk("R6 tdo_en off", tdo_en, 0);
    end

    // R11 timing of update
    slot = 6'h05; grp = 2'd0;
    go_wait();
    shift_byte(8'h05);
    update_ir = 1'b1;
    #2;
    chk("R11 no early change", {29'd0, st}, 0);
    tick();
    update_ir = 1'b0;
    chk("R11 change at edge", {29'd0, st}, 1);

    // R7 cleared by a later instruction, R9 return from single
    load(8'h12);
    chk("R7 idcode cleared", id_sel, 0);
    chk("R7 still single", {29'd0, st}, 1);
    load(8'hC0);
    chk("R9 single->wait", {29'd0, st}, 0);

    // R8 unselected stickiness
    load(8'h07);
    chk("R8 unselected", {29'd0, st}, 4);
    load(8'h05);
    chk("R8 match ignored", {29'd0, st}, 4);
    load(8'h3B);
    chk("R8 broadcast ignored", {29'd0, st}, 4);
    load(8'hC0);
    chk("R8 R9 gotowait exits", {29'd0, st}, 0);
    load(8'h07);
    go_wait();
    chk("R8 tlr exits", {29'd0, st}, 0);

    // R9 gotowait from broadcast; in wait C0 is address 00
    load(8'h3B);
    load(8'hC0);
    chk("R9 bcast->wait", {29'd0, st}, 0);
    load(8'hC0);
    chk("R9 C0 as addr 00 mismatch", {29'd0, st}, 4);
    slot = 6'h00;
    go_wait();
    load(8'hC0);
    chk("R9 C0 as addr 00 match", {29'd0, st}, 1);

    // R6 shift-IR drives in single
    shift_ir = 1'b1; tdi = 1'b0;
    tick();
    shift_ir = 1'b0;
    chk("R6 tdo_en shift-ir single", tdo_en, 1);

    // R1 collision: tlr with a matching update
    slot = 6'h05;
    go_wait();
    shift_byte(8'h05);
    tlr = 1'b1; update_ir = 1'b1;
    tick();
    tlr = 1'b0; update_ir = 1'b0;
    chk("R1 tlr beats update", {29'd0, st}, 0);
    chk("R1 idcode after collision", id_sel, 0);

    // R6 collision: shift-dr with broadcast entry
    shift_byte(8'h3B);
    update_ir = 1'b1; shift_dr = 1'b1;
    tick();
    update_ir = 1'b0;
    tick();
    shift_dr = 1'b0;
    chk("R6 bcast shift tdo_en", tdo_en, 0);
    chk("R5 bcast state", {29'd0, st}, 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule